// File: doc/BRIEF.md
# 64-bit Integer ALU with 32-bit Word Operations

This block is the integer execution datapath of a 64-bit RISC-V style core. It takes two 64-bit operands and a 4-bit operation code, and computes one of fifteen operations. These are add, subtract, the three bitwise operations, the three shifts, signed and unsigned set-less-than, and five 32-bit word variants. Each word variant computes on the low half of the operands and sign-extends its 32-bit result to the full width. Operand B is either a register value or an immediate that has already been sign-extended, so the same operation code serves both forms.

The datapath is combinational. A single register stage with a valid flag closes it. An operation presented with `in_valid` high appears on `result` one clock later, with `out_valid` high. When no operation is presented, the previous result is held. Decoding, immediate generation, the register file and exception handling sit outside this block.

Top module: `int_alu64`

## Requirements
- R1: Code 0 (add) gives A+B and code 1 (subtract) gives A-B. Both wrap modulo 2^64 and raise no flag.
- R2: Code 10 (add word) and code 11 (subtract word) compute on bits 31:0 only. They copy bit 31 of the 32-bit result into bits 63:32.
- R3: Code 5 (shift left), code 6 (logical right) and code 7 (arithmetic right) shift A by B[5:0]. All higher bits of B are ignored, and the arithmetic right shift copies A[63] into the vacated positions.
- R4: Code 12 (shift left word) and code 13 (logical right word) shift A[31:0] by B[4:0], bringing zeros in. Bits 63:32 of A and bits 63:5 of B have no effect, and bit 31 of the 32-bit result is copied into bits 63:32.
- R5: Code 14 (arithmetic right word) treats A[31:0] as a signed 32-bit value and shifts it by B[4:0], copying A[31] into the vacated positions. The 32-bit result is then sign-extended to 64 bits.
- R6: Code 8 gives 1 when A < B as signed 64-bit integers and code 9 gives 1 when A < B unsigned, otherwise 0. Bits 63:1 of the result are always zero.
- R7: Code 2 gives A AND B, code 3 gives A OR B and code 4 gives A XOR B, over all 64 bits.
- R8: Code 15 is unassigned and produces an all-zero result.
- R9: `out_valid` equals `in_valid` delayed by one clock. `result` is loaded only on a clock where `in_valid` is high and otherwise keeps its value.
- R10: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and code are presented this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B or sign-extended immediate |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Registered result |

## Verification
Any wrong internal decode, shift stage or sign-extension choice reaches `result` on the clock after the operation is issued, so each fault shows up one cycle after the stimulus that exposes it. The most sensitive points are the shift amounts 31, 32, 63 and 64, where a wrong mask width or a missing stage gives a visibly shifted or unshifted value. Operand A with its upper half set catches a logical right word shift that lets the upper half leak in. Comparing the most negative value against zero tells a signed compare apart from an unsigned one. A wrong load enable on the output register shows up as a changed `result` during an idle cycle.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SRA  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_ADDW = 4'd10,
    OP_SUBW = 4'd11,
    OP_SLLW = 4'd12,
    OP_SRLW = 4'd13,
    OP_SRAW = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_ARITH,
    RS_SHIFT,
    RS_CMP,
    RS_LOGIC
  } res_sel_e;

  typedef enum logic [1:0] {
    LF_AND,
    LF_OR,
    LF_XOR
  } logic_fn_e;

  typedef struct packed {
    res_sel_e  grp;
    logic      sub;
    logic      word;
    logic      sh_left;
    logic      sh_arith;
    logic      cmp_signed;
    logic_fn_e lfn;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              word,
  output logic [DATA_W-1:0] y
);
  localparam int EXT_W = DATA_W - WORD_W;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] full;

  // Subtraction as A + ~B + 1 keeps a single adder.
  assign b_eff = sub ? ~b : b;
  assign full  = a + b_eff + {{(DATA_W-1){1'b0}}, sub};

  always_comb begin
    if (word) y = {{EXT_W{full[WORD_W-1]}}, full[WORD_W-1:0]};
    else      y = full;
  end
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              left,
  input  logic              arith,
  input  logic              word,
  output logic [DATA_W-1:0] y
);
  localparam int SH_W  = $clog2(DATA_W);
  localparam int WSH_W = $clog2(WORD_W);
  localparam int EXT_W = DATA_W - WORD_W;

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] prep;
  logic [DATA_W-1:0] prep_rev;
  logic [DATA_W-1:0] src;
  logic              fill;
  logic [DATA_W-1:0] stage [SH_W+1];
  logic [DATA_W-1:0] shr;
  logic [DATA_W-1:0] shr_rev;
  logic [DATA_W-1:0] shifted;

  // Mask the amount to the width of the operation.
  assign amt = word ? SH_W'(b[WSH_W-1:0]) : b[SH_W-1:0];

  // Word operand: the low half, zero- or sign-extended so right shifts
  // bring the proper bit into position WORD_W-1.
  always_comb begin
    if (word) begin
      if (arith) prep = {{EXT_W{a[WORD_W-1]}}, a[WORD_W-1:0]};
      else       prep = {{EXT_W{1'b0}}, a[WORD_W-1:0]};
    end else begin
      prep = a;
    end
  end

  // Left shifts reuse the right-shift network on bit-reversed data.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign prep_rev[i] = prep[DATA_W-1-i];
    assign shr_rev[i]  = shr[DATA_W-1-i];
  end

  assign src      = left ? prep_rev : prep;
  assign fill     = arith & ~left & prep[DATA_W-1];
  assign stage[0] = src;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int S = 1 << k;
    assign stage[k+1] = amt[k] ? {{S{fill}}, stage[k][DATA_W-1:S]} : stage[k];
  end

  assign shr     = stage[SH_W];
  assign shifted = left ? shr_rev : shr;

  always_comb begin
    if (word) y = {{EXT_W{shifted[WORD_W-1]}}, shifted[WORD_W-1:0]};
    else      y = shifted;
  end
endmodule

// File: rtl/alu_compare.sv
`timescale 1ns/1ps
module alu_compare #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              signed_cmp,
  output logic [DATA_W-1:0] y
);
  logic lt_u;
  logic lt_s;
  logic sign_diff;

  assign lt_u      = a < b;
  assign sign_diff = a[DATA_W-1] ^ b[DATA_W-1];
  // With differing signs the negative operand is the smaller one.
  assign lt_s      = sign_diff ? a[DATA_W-1] : lt_u;
  assign y         = {{(DATA_W-1){1'b0}}, signed_cmp ? lt_s : lt_u};
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
module alu_logic
  import alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic_fn_e         fn,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (fn)
      LF_AND:  y = a & b;
      LF_OR:   y = a | b;
      LF_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu64.sv
`timescale 1ns/1ps
module int_alu64
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  alu_ctrl_t         ctl;
  logic [DATA_W-1:0] y_arith;
  logic [DATA_W-1:0] y_shift;
  logic [DATA_W-1:0] y_cmp;
  logic [DATA_W-1:0] y_logic;
  logic [DATA_W-1:0] y_next;

  always_comb begin
    ctl = '{grp: RS_ZERO, sub: 1'b0, word: 1'b0, sh_left: 1'b0,
            sh_arith: 1'b0, cmp_signed: 1'b0, lfn: LF_AND};
    case (op_sel)
      OP_ADD:  ctl.grp = RS_ARITH;
      OP_SUB:  begin ctl.grp = RS_ARITH; ctl.sub = 1'b1; end
      OP_ADDW: begin ctl.grp = RS_ARITH; ctl.word = 1'b1; end
      OP_SUBW: begin ctl.grp = RS_ARITH; ctl.sub = 1'b1; ctl.word = 1'b1; end
      OP_AND:  begin ctl.grp = RS_LOGIC; ctl.lfn = LF_AND; end
      OP_OR:   begin ctl.grp = RS_LOGIC; ctl.lfn = LF_OR;  end
      OP_XOR:  begin ctl.grp = RS_LOGIC; ctl.lfn = LF_XOR; end
      OP_SLL:  begin ctl.grp = RS_SHIFT; ctl.sh_left = 1'b1; end
      OP_SRL:  ctl.grp = RS_SHIFT;
      OP_SRA:  begin ctl.grp = RS_SHIFT; ctl.sh_arith = 1'b1; end
      OP_SLLW: begin ctl.grp = RS_SHIFT; ctl.sh_left = 1'b1; ctl.word = 1'b1; end
      OP_SRLW: begin ctl.grp = RS_SHIFT; ctl.word = 1'b1; end
      OP_SRAW: begin ctl.grp = RS_SHIFT; ctl.sh_arith = 1'b1; ctl.word = 1'b1; end
      OP_SLT:  begin ctl.grp = RS_CMP; ctl.cmp_signed = 1'b1; end
      OP_SLTU: ctl.grp = RS_CMP;
      default: ctl.grp = RS_ZERO;
    endcase
  end

  alu_addsub #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(ctl.sub), .word(ctl.word), .y(y_arith)
  );

  alu_shifter #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_shift (
    .a(opnd_a), .b(opnd_b), .left(ctl.sh_left), .arith(ctl.sh_arith),
    .word(ctl.word), .y(y_shift)
  );

  alu_compare #(.DATA_W(DATA_W)) u_cmp (
    .a(opnd_a), .b(opnd_b), .signed_cmp(ctl.cmp_signed), .y(y_cmp)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(opnd_a), .b(opnd_b), .fn(ctl.lfn), .y(y_logic)
  );

  always_comb begin
    case (ctl.grp)
      RS_ARITH: y_next = y_arith;
      RS_SHIFT: y_next = y_shift;
      RS_CMP:   y_next = y_cmp;
      RS_LOGIC: y_next = y_logic;
      default:  y_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= y_next;
    end
  end
endmodule

// File: rtl/alu_chk.sv
`timescale 1ns/1ps
module alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  localparam int EXT_W = DATA_W - WORD_W;

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  // R1
  add_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_ADD) |=> result == $past(opnd_a) + $past(opnd_b));

  // R6
  cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OP_SLT || op_sel == OP_SLTU)) |=> result[DATA_W-1:1] == '0);

  // R2
  word_sext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == OP_ADDW || op_sel == OP_SUBW || op_sel == OP_SLLW ||
                  op_sel == OP_SRLW || op_sel == OP_SRAW))
    |=> result[DATA_W-1:WORD_W] == {EXT_W{result[WORD_W-1]}});

  // R8
  unassigned_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == OP_NONE) |=> result == '0);
endmodule

bind int_alu64 alu_chk #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_alu_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
);

// File: tb/test_int_alu64.sv
`timescale 1ns/1ps
module test_int_alu64;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [63:0] exp_q [$];
  logic [3:0]  op_q  [$];
  logic [63:0] last_res = '0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  int_alu64 i_int_alu64 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:          return "R1";
      4'd10, 4'd11:        return "R2";
      4'd5, 4'd6, 4'd7:    return "R3";
      4'd12, 4'd13:        return "R4";
      4'd14:               return "R5";
      4'd8, 4'd9:          return "R6";
      4'd2, 4'd3, 4'd4:    return "R7";
      default:             return "R8";
    endcase
  endfunction

  function automatic logic [63:0] sx32(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(logic [3:0] op, logic [63:0] a, logic [63:0] b);
    logic [31:0] w;
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return a << b[5:0];
      4'd6:  return a >> b[5:0];
      4'd7:  return $signed(a) >>> b[5:0];
      4'd8:  return {63'd0, $signed(a) < $signed(b)};
      4'd9:  return {63'd0, a < b};
      4'd10: begin w = a[31:0] + b[31:0]; return sx32(w); end
      4'd11: begin w = a[31:0] - b[31:0]; return sx32(w); end
      4'd12: begin w = a[31:0] << b[4:0]; return sx32(w); end
      4'd13: begin w = a[31:0] >> b[4:0]; return sx32(w); end
      4'd14: begin w = $signed(a[31:0]) >>> b[4:0]; return sx32(w); end
      default: return 64'd0;
    endcase
  endfunction

  // Driver: presents one operation and queues its expected result.
  task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    op_sel   = op;
    opnd_a   = a;
    opnd_b   = b;
    exp_q.push_back(model(op, a, b));
    op_q.push_back(op);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_sel   = 4'd0;
      opnd_a   = 64'hDEAD_BEEF_0BAD_F00D;
      opnd_b   = 64'h1234_5678_9ABC_DEF0;
    end
  endtask

  // Monitor: compares each produced result with the head of the queue.
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R9: out_valid with no pending item, result=%h expected none", result);
        end else begin
          logic [63:0] e;
          logic [3:0]  o;
          e = exp_q.pop_front();
          o = op_q.pop_front();
          if (result !== e) begin
            errors++;
            $display("FAIL %s: op=%0d result=%h expected=%h", req_of(o), o, result, e);
          end
        end
        last_res = result;
      end else begin
        // R9: an idle cycle must leave the result unchanged
        checks++;
        if (result !== last_res) begin
          errors++;
          $display("FAIL R9: idle result=%h expected=%h", result, last_res);
        end
      end
    end
  end

  function automatic logic [63:0] next_rng(logic [63:0] s);
    logic [63:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0) begin
      errors++;
      $display("FAIL R10: out_valid=%b result=%h expected 0/0", out_valid, result);
    end
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1;

    // R1 wrap
    drive(OP_ADD, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    drive(OP_SUB, 64'd0, 64'd1);
    // R2 word add/sub with upper garbage
    drive(OP_ADDW, 64'hABCD_0000_7FFF_FFFF, 64'd1);
    drive(OP_SUBW, 64'h1111_2222_0000_0000, 64'd1);
    // R3 shift amounts 63, 64 (masked to 0), 32, and high bits of B ignored
    drive(OP_SLL, 64'd1, 64'd63);
    drive(OP_SLL, 64'h0123_4567_89AB_CDEF, 64'd64);
    drive(OP_SRL, 64'h8000_0000_0000_0001, 64'd32);
    drive(OP_SRA, 64'h8000_0000_0000_0000, 64'd63);
    drive(OP_SRA, 64'hF000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FF44);
    // R4 word shifts at 31 and 32 (masked), upper A must not leak
    drive(OP_SLLW, 64'd1, 64'd31);
    drive(OP_SLLW, 64'hFFFF_FFFF_0000_0003, 64'd32);
    drive(OP_SRLW, 64'hFFFF_FFFF_8000_0000, 64'd31);
    drive(OP_SRLW, 64'hFFFF_FFFF_0000_0F00, 64'd4);
    // R5 arithmetic word shift
    drive(OP_SRAW, 64'h0000_0000_8000_0000, 64'd31);
    drive(OP_SRAW, 64'hFFFF_FFFF_7000_0000, 64'd3);
    // R6 most negative against zero
    drive(OP_SLT,  64'h8000_0000_0000_0000, 64'd0);
    drive(OP_SLTU, 64'h8000_0000_0000_0000, 64'd0);
    drive(OP_SLT,  64'd0, 64'h8000_0000_0000_0000);
    drive(OP_SLTU, 64'd0, 64'h8000_0000_0000_0000);
    // R7 bitwise
    drive(OP_AND, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFFFF_0000_FFFF_0000);
    drive(OP_OR,  64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0000_0000_0001);
    drive(OP_XOR, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555);
    // R8 unassigned code
    drive(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R9 idle gap holds the result
    idle(4);

    for (int n = 0; n < 300; n++) begin
      logic [63:0] a;
      logic [63:0] b;
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = rng;
      if (n % 5 == 0) b = {58'd0, b[5:0]};
      drive(4'(n % 16), a, b);
      if (n % 7 == 3) idle(1 + n % 3);
    end
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: %0d results missing, expected 0", exp_q.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL R9: watchdog expired, pending=%0d expected 0", exp_q.size());
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule